// File: doc/BRIEF.md
# Frame-Synchronous Parallel Scrambler

This block whitens a 64-bit word stream on the transmit side and restores it on the receive side of a framed optical link. Every valid word is XORed with a keystream taken from a 16-bit linear feedback shift register. The register is unrolled so that it advances 64 bit-steps in each clock. Because the generator restarts from a fixed seed at a known point in every frame, scrambling and descrambling are the same operation. The same module serves both directions.

The first word of a frame is flagged by a start-of-frame input. Its leading six bytes carry the alignment pattern. These bytes are passed through untouched, and the generator does not step across them. The remaining bits of that word start the keystream from the all-ones seed. The words that follow continue the keystream without a break. Idle cycles, where the valid input is low, freeze the generator. Results appear one clock after the word is accepted, and they carry a registered copy of the valid flag.

Top module: `fs_scrambler`

## Requirements
- R1: While the reset input is low, and until the first valid word has been accepted after its release, out_vld is 0 and out_data is all zeros.
- R2: out_vld in each cycle equals in_vld of the previous cycle.
- R3: For a word accepted with in_sof high, out_data bits 63 down to 16 equal in_data bits 63 down to 16 one cycle later.
- R4: For a word accepted with in_sof high, the generator is loaded with all ones. Bits 15 down to 0 are XORed with the first 16 keystream bits, bit 15 first. With the keystream of R7, this inverts those 16 bits.
- R5: For a valid word accepted with in_sof low, all 64 bits are XORed with the next 64 keystream bits, in the order bit 63 first through bit 0 last. The stream continues from where the previous valid word stopped.
- R6: A cycle with in_vld low does not advance the generator, and it produces out_data of all zeros.
- R7: The keystream is defined serially. The state is r[15:0]. Each step emits r[15], then shifts to {r[14:0], r[0]^r[2]^r[11]^r[15]}; this realises 1 + x + x^3 + x^12 + x^16. Reset leaves r at all ones.
- R8: Feeding the output into a second instance, with in_sof delayed by one cycle, returns the original data two cycles after it was applied.
- R9: The keystream taken from one frame start repeats with a period of 65,535 bits.
- R10: A start-of-frame word in the middle of a stream restarts the keystream, whatever state the generator held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input word is valid |
| in_sof | input | 1 | Input word is the first word of a frame (alignment bytes in bits 63..16) |
| in_data | input | 64 | Input word, bit 63 transmitted first |
| out_vld | output | 1 | Output word is valid |
| out_data | output | 64 | Scrambled or descrambled word |

## Verification
Every scrambled word and its valid flag are due exactly one clock after the word is applied. The chained descrambler returns the original word two clocks after it was applied. The bench drives inputs on the falling edge and compares outputs at the next falling edge against a bit-serial model of the register. The model is stepped only for valid words. The recovery check compares against the word applied one step earlier. Reset checks are taken while reset is held and during the synchronous release cycles. The period check gathers the keystream over more than 1,024 consecutive words before it compares.

// File: rtl/fsscr_pkg.sv
package fsscr_pkg;

  localparam int unsigned FSSCR_DATA_W    = 64;
  localparam int unsigned FSSCR_LFSR_W    = 16;
  localparam int unsigned FSSCR_HDR_BYTES = 6;
  // feedback taps on r[0], r[2], r[11], r[15]
  localparam logic [15:0] FSSCR_TAPS      = 16'h8805;
  localparam logic [15:0] FSSCR_SEED      = 16'hFFFF;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FRAME = 2'd1,
    WK_BODY  = 2'd2
  } word_kind_e;

endpackage

// File: rtl/fsscr_rst_sync.sv
module fsscr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/fsscr_advance.sv
// Unrolled generator: STEPS serial steps of the register in one clock.
// The XOR matrices are computed at elaboration from the feedback taps.
module fsscr_advance #(
  parameter int            W     = 16,
  parameter int            STEPS = 64,
  parameter logic [W-1:0]  TAPS  = 16'h8805
) (
  input  logic [W-1:0]     state_i,
  output logic [STEPS-1:0] ks_o,    // ks_o[0] is the first emitted bit
  output logic [W-1:0]     next_o
);

  typedef logic [W-1:0][W-1:0] smat_t;

  // Each row is the set of seed bits whose XOR gives that state bit after n steps.
  function automatic smat_t f_walk(input int n);
    smat_t        cur;
    logic [W-1:0] fb;
    for (int i = 0; i < W; i++) cur[i] = W'(1) << i;
    for (int s = 0; s < n; s++) begin
      fb = '0;
      for (int i = 0; i < W; i++) if (TAPS[i]) fb = fb ^ cur[i];
      for (int i = W-1; i > 0; i--) cur[i] = cur[i-1];
      cur[0] = fb;
    end
    return cur;
  endfunction

  function automatic logic [STEPS-1:0][W-1:0] f_ks_rows();
    logic [STEPS-1:0][W-1:0] rows;
    smat_t                   m;
    for (int j = 0; j < STEPS; j++) begin
      m       = f_walk(j);
      rows[j] = m[W-1];
    end
    return rows;
  endfunction

  localparam logic [STEPS-1:0][W-1:0] KS_ROWS = f_ks_rows();
  localparam smat_t                   NX_ROWS = f_walk(STEPS);

  genvar gj, gi;
  generate
    for (gj = 0; gj < STEPS; gj++) begin : g_ks
      assign ks_o[gj] = ^(state_i & KS_ROWS[gj]);
    end
    for (gi = 0; gi < W; gi++) begin : g_nx
      assign next_o[gi] = ^(state_i & NX_ROWS[gi]);
    end
  endgenerate

endmodule

// File: rtl/fsscr_mix.sv
// Places a keystream (first bit at the top) into the low LEN bits of a word and XORs it.
module fsscr_mix #(
  parameter int DATA_W = 64,
  parameter int LEN    = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN-1:0]    ks_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] ks_word;

  genvar gk;
  generate
    for (gk = 0; gk < LEN; gk++) begin : g_place
      assign ks_word[LEN-1-gk] = ks_i[gk];
    end
    if (LEN < DATA_W) begin : g_pad
      assign ks_word[DATA_W-1:LEN] = '0;
    end
  endgenerate

  assign data_o = data_i ^ ks_word;

endmodule

// File: rtl/fs_scrambler.sv
module fs_scrambler
  import fsscr_pkg::*;
#(
  parameter int                 DATA_W    = FSSCR_DATA_W,
  parameter int                 LFSR_W    = FSSCR_LFSR_W,
  parameter int                 HDR_BYTES = FSSCR_HDR_BYTES,
  parameter logic [LFSR_W-1:0]  TAPS      = FSSCR_TAPS,
  parameter logic [LFSR_W-1:0]  SEED      = FSSCR_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  localparam int HDR_W = HDR_BYTES * 8;
  localparam int PAY_W = DATA_W - HDR_W;

  logic              rst_q;
  logic [LFSR_W-1:0] state_q, state_d;
  logic              state_en;
  logic              vld_q;
  logic [DATA_W-1:0] data_q, data_d;
  word_kind_e        kind;

  logic [DATA_W-1:0] body_ks;
  logic [LFSR_W-1:0] body_next;
  logic [PAY_W-1:0]  head_ks;
  logic [LFSR_W-1:0] head_next;
  logic [DATA_W-1:0] body_mixed;
  logic [DATA_W-1:0] head_mixed;

  fsscr_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // full word: continue from the running state
  fsscr_advance #(.W(LFSR_W), .STEPS(DATA_W), .TAPS(TAPS)) u_body (
    .state_i (state_q),
    .ks_o    (body_ks),
    .next_o  (body_next)
  );

  // frame-start word: restart from the seed after the alignment bytes
  fsscr_advance #(.W(LFSR_W), .STEPS(PAY_W), .TAPS(TAPS)) u_head (
    .state_i (SEED),
    .ks_o    (head_ks),
    .next_o  (head_next)
  );

  fsscr_mix #(.DATA_W(DATA_W), .LEN(DATA_W)) u_mix_body (
    .data_i (in_data),
    .ks_i   (body_ks),
    .data_o (body_mixed)
  );

  fsscr_mix #(.DATA_W(DATA_W), .LEN(PAY_W)) u_mix_head (
    .data_i (in_data),
    .ks_i   (head_ks),
    .data_o (head_mixed)
  );

  always_comb begin
    if (!in_vld)     kind = WK_IDLE;
    else if (in_sof) kind = WK_FRAME;
    else             kind = WK_BODY;
  end

  always_comb begin
    state_en = 1'b0;
    state_d  = state_q;
    data_d   = '0;
    case (kind)
      WK_FRAME: begin
        state_en = 1'b1;
        state_d  = head_next;
        data_d   = head_mixed;
      end
      WK_BODY: begin
        state_en = 1'b1;
        state_d  = body_next;
        data_d   = body_mixed;
      end
      default: begin
        state_en = 1'b0;
        state_d  = state_q;
        data_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= SEED;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      vld_q  <= in_vld;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;

endmodule

// File: rtl/fsscr_chk.sv
module fsscr_chk #(
  parameter int DATA_W = 64,
  parameter int LFSR_W = 16,
  parameter int HDR_W  = 48
) (
  input logic              clk,
  input logic              rst_q,
  input logic              in_vld,
  input logic              in_sof,
  input logic [DATA_W-1:0] in_data,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_data,
  input logic [LFSR_W-1:0] state_q
);

  logic armed;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!armed)
    out_vld == $past(in_vld));

  // R3
  hdr_pass_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(in_vld && in_sof) |->
      (out_vld && out_data[DATA_W-1 -: HDR_W] == $past(in_data[DATA_W-1 -: HDR_W])));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !out_vld |-> (out_data == '0));

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    !in_vld |=> $stable(state_q));

endmodule

bind fs_scrambler fsscr_chk #(
  .DATA_W (DATA_W),
  .LFSR_W (LFSR_W),
  .HDR_W  (HDR_W)
) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .in_vld   (in_vld),
  .in_sof   (in_sof),
  .in_data  (in_data),
  .out_vld  (out_vld),
  .out_data (out_data),
  .state_q  (state_q)
);

// File: tb/sim_fs_scrambler.sv
module sim_fs_scrambler;

  localparam int CLK_PERIOD = 6;
  localparam int DW         = 64;
  localparam int NVEC       = 12;
  localparam int PERIOD     = 65535;
  localparam int NWORDS     = 1030;

  // {valid, start of frame, data}
  localparam logic [DW+1:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 64'h0000_0000_0000_0000},
    {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b1, 64'hF6F6_F628_2828_1234},
    {1'b1, 1'b0, 64'h0000_0000_0000_0000},
    {1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567},
    {1'b0, 1'b1, 64'h5555_5555_5555_5555},
    {1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b0, 64'h8000_0000_0000_0001},
    {1'b1, 1'b1, 64'hF6F6_F628_2828_0000},
    {1'b0, 1'b0, 64'h0000_0000_0000_0000},
    {1'b1, 1'b0, 64'hA5A5_5A5A_C3C3_3C3C},
    {1'b1, 1'b0, 64'h0123_4567_89AB_CDEF}
  };

  logic          clk;
  logic          rst_n;
  logic          in_vld, in_sof;
  logic [DW-1:0] in_data;
  logic          out_vld;
  logic [DW-1:0] out_data;
  logic          sof_d;
  logic          rx_vld;
  logic [DW-1:0] rx_data;

  int   n_checks, n_errors;
  bit   done;
  logic [15:0] mr;
  bit   ks_bits [PERIOD + 512];

  fs_scrambler u0 (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_sof (in_sof),
    .in_data (in_data), .out_vld (out_vld), .out_data (out_data)
  );

  fs_scrambler u1 (
    .clk (clk), .rst_n (rst_n), .in_vld (out_vld), .in_sof (sof_d),
    .in_data (out_data), .out_vld (rx_vld), .out_data (rx_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_d <= 1'b0;
    else        sof_d <= in_sof;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic adv(output bit o);
    o  = mr[15];
    mr = {mr[14:0], mr[0] ^ mr[2] ^ mr[11] ^ mr[15]};
  endtask

  // serial reference (R7): one bit at a time, bit 63 first
  task automatic model_word(input bit sof, input logic [DW-1:0] d,
                            output logic [DW-1:0] e);
    bit k;
    e = d;
    if (sof) begin
      mr = 16'hFFFF;
      for (int j = 0; j < 16; j++) begin adv(k); e[15-j] = d[15-j] ^ k; end
    end else begin
      for (int j = 0; j < DW; j++) begin adv(k); e[DW-1-j] = d[DW-1-j] ^ k; end
    end
  endtask

  task automatic drive(input bit v, input bit s, input logic [DW-1:0] d);
    in_vld = v; in_sof = s; in_data = d;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] exp;
    logic [DW-1:0] prev_d;
    bit            prev_v;
    int            nb;
    bit            per_ok;
    n_checks = 0; n_errors = 0; done = 0;
    in_vld = 0; in_sof = 0; in_data = '0;
    rst_n = 0;
    mr = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_vld == 1'b0, "R1 vld in reset", {63'd0, out_vld}, '0);
    check(out_data == '0, "R1 data in reset", out_data, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && out_data == '0, "R1 after release", out_data, '0);

    // vector table: R2 R3 R4 R5 R6 R10 against serial model, R8 through u1
    prev_v = 0; prev_d = '0;
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][DW+1], VEC[i][DW], VEC[i][DW-1:0]);
      if (VEC[i][DW+1]) begin
        model_word(VEC[i][DW], VEC[i][DW-1:0], exp);
        check(out_vld == 1'b1, "R2 vld follows", {63'd0, out_vld}, 64'd1);
        check(out_data == exp, VEC[i][DW] ? "R3/R4/R10 frame word" : "R5 body word",
              out_data, exp);
      end else begin
        check(out_vld == 1'b0, "R2 idle vld", {63'd0, out_vld}, '0);
        check(out_data == '0, "R6 idle data", out_data, '0);
      end
      if (prev_v) check(rx_vld && rx_data == prev_d, "R8 recovered", rx_data, prev_d);
      prev_v = VEC[i][DW+1];
      prev_d = VEC[i][DW-1:0];
    end

    // R4: frame word with zero payload gives the inverted seed in the low 16 bits
    drive(1'b1, 1'b1, 64'h1122_3344_5566_0000);
    model_word(1'b1, 64'h1122_3344_5566_0000, exp);
    check(out_data == 64'h1122_3344_5566_FFFF, "R4 seed bits", out_data,
          64'h1122_3344_5566_FFFF);
    check(rx_vld && rx_data == prev_d, "R8 recovered", rx_data, prev_d);

    // R9: keystream period over a long run of zero words
    nb = 0;
    for (int j = 0; j < 16; j++) ks_bits[nb++] = out_data[15-j];
    for (int w = 0; w < NWORDS; w++) begin
      drive(1'b1, 1'b0, '0);
      model_word(1'b0, '0, exp);
      check(out_data == exp, "R5 long run", out_data, exp);
      for (int j = 0; j < DW; j++) if (nb < PERIOD + 512) ks_bits[nb++] = out_data[DW-1-j];
    end
    per_ok = 1;
    for (int k = 0; k < 256; k++) if (ks_bits[k] != ks_bits[k + PERIOD]) per_ok = 0;
    check(per_ok, "R9 period 65535", {63'd0, per_ok}, 64'd1);

    // R6: idle cycles do not move the generator
    drive(1'b0, 1'b0, 64'hFFFF_0000_FFFF_0000);
    drive(1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0);
    check(out_data == '0, "R6 idle data", out_data, '0);
    drive(1'b1, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F);
    model_word(1'b0, 64'h0F0F_0F0F_0F0F_0F0F, exp);
    check(out_data == exp, "R6 no advance while idle", out_data, exp);

    drive(1'b0, 1'b0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule